// File: doc/BRIEF.md
# Serial-Frame 1-Wire Bit Master

This block drives a 1-Wire bus by turning each bus slot into one asynchronous serial frame: a low start bit, eight data bits sent least significant bit first, and a high stop bit. The frame goes out on an open-drain line. The block receives the same line at the same time, so it sees both its own frame and anything a device adds to it. The length of the low pulse comes from two choices: the pattern byte and the bit period. A slow period is used for reset/presence. A fast period is used for write and read slots.

A command port accepts one of three operations. The block shows busy while the frame is on the wire. It then returns one result bit with a one-cycle done strobe. For a reset, the result is the presence flag. For a read or write slot, it is the bit seen on the bus. The received byte is assembled from a two-flop synchronized copy of the bus, sampled at the middle of each bit. The result is decoded by comparing that byte with the pattern that was sent.

Top module: `owire_uart_master`

## Requirements
- R1: After reset, busy_o, done_o, result_o and bus_pull_o are all 0.
- R2: Operation code 2'b00 (reset/presence) sends pattern 0xF0 with a bit period of SLOW_DIV clocks, so bus_pull_o is high for exactly 5*SLOW_DIV cycles.
- R3: Operation code 2'b01 (write) uses a period of FAST_DIV clocks. With cmd_bit_i=0 it sends 0x80, so bus_pull_o is high for 8*FAST_DIV cycles. With cmd_bit_i=1 it sends 0xFF, so bus_pull_o is high for FAST_DIV cycles.
- R4: Operation code 2'b10 (read) sends 0xFF with a period of FAST_DIV clocks, so bus_pull_o is high for FAST_DIV cycles.
- R5: Each frame is a low start bit, then 8 data bits least significant first, then a high stop bit. bus_pull_o is 0 from the start of the stop bit until the next accepted command.
- R6: Each received bit is the synchronized bus level in cycle DIV/2 of that bit period, where cycle 0 is the first cycle of the bit. A device pulse that misses every sample point does not change the result.
- R7: For a reset operation, result_o is 1 exactly when the received byte differs from 0xF0.
- R8: For a read or write operation, result_o is 1 exactly when the received byte equals 0xFF.
- R9: busy_o is high for exactly 9*DIV + DIV/2 + 1 cycles after the accepting edge. done_o is high for one cycle: the first cycle in which busy_o is low again, and result_o is valid in that cycle.
- R10: A command is ignored if it arrives while busy_o is high, or if it carries operation code 2'b11.
- R11: A command with cmd_valid_i high is accepted on the next edge whenever busy_o is low, including the cycle in which done_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cmd_valid_i | input | 1 | Command request |
| cmd_op_i | input | 2 | 00 reset/presence, 01 write, 10 read, 11 none |
| cmd_bit_i | input | 1 | Bit value for a write |
| busy_o | output | 1 | A frame is in progress |
| done_o | output | 1 | One-cycle completion strobe |
| result_o | output | 1 | Presence flag or slot bit |
| bus_i | input | 1 | Level of the shared bus line (asynchronous) |
| bus_pull_o | output | 1 | 1 drives the open-drain line low |

## Verification
Most internal faults show up at bus_pull_o within the frame they affect. A wrong divider limit, a wrong shift order or a wrong pattern byte changes the low time by whole multiples of the bit period in the first slot. A misplaced sample point or a wrong receive assembly is only visible at the end of the frame, as a wrong result_o. Devices are modelled as pulses that either cover a sample point or fall between two. A stuck busy or done state shows up as a wrong busy length, or as a lost or doubled strobe, on the very next command.

// File: rtl/owu_pkg.sv
package owu_pkg;

    typedef enum logic [1:0] {
        OP_RESET = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_NONE  = 2'b11
    } owu_op_e;

    localparam int FRAME_BITS = 10;
    localparam int STOP_IDX   = FRAME_BITS - 1;
    localparam logic [7:0] PAT_RESET = 8'hF0;
    localparam logic [7:0] PAT_ZERO  = 8'h80;
    localparam logic [7:0] PAT_ONE   = 8'hFF;

    function automatic logic [7:0] owu_pattern(owu_op_e op, logic bit_val);
        logic [7:0] pat;
        case (op)
            OP_RESET: pat = PAT_RESET;
            OP_WRITE: pat = bit_val ? PAT_ONE : PAT_ZERO;
            default:  pat = PAT_ONE;
        endcase
        return pat;
    endfunction

endpackage

// File: rtl/owu_bitclk.sv
module owu_bitclk #(
    parameter int SLOW_DIV = 26042,
    parameter int FAST_DIV = 2170
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    input  logic fast_i,
    output logic mid_o,
    output logic end_o
);
    localparam int MAX_DIV = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
    localparam int CNT_W   = $clog2(MAX_DIV + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] lim, half;

    always_comb begin
        lim   = fast_i ? CNT_W'(FAST_DIV - 1) : CNT_W'(SLOW_DIV - 1);
        half  = fast_i ? CNT_W'(FAST_DIV / 2) : CNT_W'(SLOW_DIV / 2);
        mid_o = run_i && (cnt_q == half);
        end_o = run_i && (cnt_q == lim);
        if (!run_i || end_o) cnt_d = '0;
        else                 cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    // R6
    cnt_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_i |-> (cnt_q <= lim));

endmodule

// File: rtl/owu_shifter.sv
module owu_shifter
    import owu_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       run_i,
    input  logic       load_i,
    input  logic [7:0] byte_i,
    input  logic       mid_i,
    input  logic       end_i,
    input  logic       rx_bit_i,
    output logic       pull_o,
    output logic       stop_seen_o,
    output logic [7:0] rx_byte_o
);
    typedef struct packed {
        logic [FRAME_BITS-1:0] tx;
        logic [3:0]            idx;
        logic [7:0]            rx;
    } shf_t;

    shf_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load_i) begin
            s_d.tx  = {1'b1, byte_i, 1'b0};
            s_d.idx = '0;
            s_d.rx  = '0;
        end else begin
            if (mid_i && s_q.idx >= 4'd1 && s_q.idx <= 4'd8)
                s_d.rx = {rx_bit_i, s_q.rx[7:1]};
            if (end_i) begin
                s_d.tx  = {1'b1, s_q.tx[FRAME_BITS-1:1]};
                s_d.idx = s_q.idx + 4'd1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= '{tx: '1, idx: '0, rx: '0};
        else         s_q <= s_d;
    end

    assign pull_o      = run_i && !s_q.tx[0];
    assign stop_seen_o = mid_i && (s_q.idx == 4'(STOP_IDX));
    assign rx_byte_o   = s_q.rx;

    // R5
    idx_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_i |-> (s_q.idx <= 4'(STOP_IDX)));

    // R5
    stop_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && s_q.idx == 4'(STOP_IDX)) |-> !pull_o);

endmodule

// File: rtl/owire_uart_master.sv
module owire_uart_master
    import owu_pkg::*;
#(
    parameter int CLK_HZ    = 250_000_000,
    parameter int SLOW_BAUD = 9600,
    parameter int FAST_BAUD = 115200,
    parameter int SLOW_DIV  = (CLK_HZ + SLOW_BAUD / 2) / SLOW_BAUD,
    parameter int FAST_DIV  = (CLK_HZ + FAST_BAUD / 2) / FAST_BAUD
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       cmd_valid_i,
    input  logic [1:0] cmd_op_i,
    input  logic       cmd_bit_i,
    output logic       busy_o,
    output logic       done_o,
    output logic       result_o,
    input  logic       bus_i,
    output logic       bus_pull_o
);
    typedef struct packed {
        logic       busy;
        owu_op_e    op;
        logic       done;
        logic       result;
        logic [1:0] sync;
    } ctl_t;

    ctl_t c_d, c_q;
    logic accept, mid, fin, stop_seen;
    logic [7:0] rx_byte;
    owu_op_e cmd_op;

    assign cmd_op = owu_op_e'(cmd_op_i);
    assign accept = cmd_valid_i && !c_q.busy && (cmd_op != OP_NONE);

    owu_bitclk #(.SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) bitclk_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (c_q.busy),
        .fast_i (c_q.op != OP_RESET),
        .mid_o  (mid),
        .end_o  (fin)
    );

    owu_shifter shifter_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .run_i       (c_q.busy),
        .load_i      (accept),
        .byte_i      (owu_pattern(cmd_op, cmd_bit_i)),
        .mid_i       (mid),
        .end_i       (fin),
        .rx_bit_i    (c_q.sync[1]),
        .pull_o      (bus_pull_o),
        .stop_seen_o (stop_seen),
        .rx_byte_o   (rx_byte)
    );

    always_comb begin
        c_d      = c_q;
        c_d.sync = {c_q.sync[0], bus_i};
        c_d.done = 1'b0;
        if (accept) begin
            c_d.busy = 1'b1;
            c_d.op   = cmd_op;
        end else if (c_q.busy && stop_seen) begin
            c_d.busy   = 1'b0;
            c_d.done   = 1'b1;
            c_d.result = (c_q.op == OP_RESET) ? (rx_byte != PAT_RESET)
                                              : (rx_byte == PAT_ONE);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) c_q <= '{busy: 1'b0, op: OP_RESET, done: 1'b0,
                              result: 1'b0, sync: 2'b11};
        else         c_q <= c_d;
    end

    assign busy_o   = c_q.busy;
    assign done_o   = c_q.done;
    assign result_o = c_q.result;

    // R1
    idle_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> !bus_pull_o);

    // R5
    start_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> bus_pull_o);

    // R9
    done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R9
    done_after_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (!busy_o && $past(busy_o)));

    // R10
    ignore_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && cmd_valid_i) |=> $stable(c_q.op));

endmodule

// File: tb/owire_uart_master_tb.sv
`timescale 1ns/1ps
module owire_uart_master_tb_top;
    localparam int SD = 40;
    localparam int FD = 12;

    typedef struct packed {
        logic [1:0]  op;
        logic        b;
        logic [15:0] dly;
        logic [15:0] len;
        logic        exp;
    } vec_t;

    // dev pulse visible to the sampler in states dly+2 .. dly+len+1
    localparam vec_t VECS [8] = '{
        '{2'b00, 1'b0, 16'd0,   16'd0,  1'b0}, // R7 no device
        '{2'b00, 1'b0, 16'd230, 16'd60, 1'b1}, // R7 pulse over sample 260
        '{2'b00, 1'b0, 16'd225, 16'd20, 1'b0}, // R6 pulse between samples
        '{2'b01, 1'b1, 16'd0,   16'd0,  1'b1}, // R8 write 1
        '{2'b01, 1'b0, 16'd0,   16'd0,  1'b0}, // R8 write 0
        '{2'b10, 1'b0, 16'd0,   16'd0,  1'b1}, // R8 read 1
        '{2'b10, 1'b0, 16'd10,  16'd15, 1'b0}, // R8 read 0
        '{2'b10, 1'b0, 16'd18,  16'd8,  1'b1}  // R6 pulse misses sample
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_valid = 1'b0, cmd_bit = 1'b0, dev_pull = 1'b0;
    logic [1:0] cmd_op = 2'b00;
    logic busy_o, done_o, result_o, bus_pull_o, bus;
    int checks = 0, fails = 0;

    always #2 clk = ~clk;
    assign bus = !(bus_pull_o || dev_pull);

    owire_uart_master #(.SLOW_DIV(SD), .FAST_DIV(FD)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
        .cmd_bit_i(cmd_bit), .busy_o(busy_o), .done_o(done_o),
        .result_o(result_o), .bus_i(bus), .bus_pull_o(bus_pull_o));

    task automatic chk(input bit ok, input string msg, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d", msg, act, exp);
        end
    endtask

    task automatic run_op(input logic [1:0] op, input logic b, input int dly,
                          input int len, input int intrude, input logic exp_res);
        int d, k, busy_n, low_n, exp_low;
        d = (op == 2'b00) ? SD : FD;
        exp_low = (op == 2'b00) ? 5 * SD : ((op == 2'b01 && !b) ? 8 * FD : FD);
        cmd_valid = 1'b1; cmd_op = op; cmd_bit = b;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(busy_o == 1'b1, "R11 command accepted", int'(busy_o), 1);
        k = 0; busy_n = 0; low_n = 0;
        while (!done_o && k < 4000) begin
            busy_n += int'(busy_o);
            low_n  += int'(bus_pull_o);
            dev_pull  = (k >= dly) && (k < dly + len);
            cmd_valid = (k == intrude);
            cmd_op    = 2'b00;
            @(negedge clk);
            k++;
        end
        dev_pull = 1'b0; cmd_valid = 1'b0;
        chk(done_o == 1'b1, "R9 done seen", int'(done_o), 1);
        chk(busy_n == 9 * d + d / 2 + 1, "R9 busy length", busy_n, 9 * d + d / 2 + 1);
        if (op == 2'b00) chk(low_n == exp_low, "R2 R5 reset low time", low_n, exp_low);
        else if (op == 2'b01) chk(low_n == exp_low, "R3 R5 write low time", low_n, exp_low);
        else chk(low_n == exp_low, "R4 R5 read low time", low_n, exp_low);
        if (op == 2'b00) chk(result_o == exp_res, "R6 R7 presence", int'(result_o), int'(exp_res));
        else chk(result_o == exp_res, "R6 R8 slot bit", int'(result_o), int'(exp_res));
        chk(bus_pull_o == 1'b0, "R5 released after frame", int'(bus_pull_o), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired act=0 exp=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy_o == 1'b0, "R1 busy reset", int'(busy_o), 0);
        chk(done_o == 1'b0, "R1 done reset", int'(done_o), 0);
        chk(result_o == 1'b0, "R1 result reset", int'(result_o), 0);
        chk(bus_pull_o == 1'b0, "R1 pull reset", int'(bus_pull_o), 0);

        foreach (VECS[i]) begin
            run_op(VECS[i].op, VECS[i].b, int'(VECS[i].dly), int'(VECS[i].len), -1, VECS[i].exp);
            @(negedge clk);
            chk(done_o == 1'b0, "R9 done single cycle", int'(done_o), 0);
            repeat (3) @(negedge clk);
        end

        // R10: reset request during a read slot must not disturb it
        run_op(2'b10, 1'b0, 0, 0, 20, 1'b1);
        repeat (3) @(negedge clk);

        // R10: operation code 11 is ignored
        cmd_valid = 1'b1; cmd_op = 2'b11;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(busy_o == 1'b0, "R10 op 11 not accepted", int'(busy_o), 0);
        chk(bus_pull_o == 1'b0, "R10 op 11 no pull", int'(bus_pull_o), 0);
        repeat (3) @(negedge clk);
        chk(done_o == 1'b0, "R10 op 11 no done", int'(done_o), 0);

        // R11: next command issued in the done cycle
        run_op(2'b10, 1'b0, 0, 0, -1, 1'b1);
        run_op(2'b01, 1'b0, 0, 0, -1, 1'b0);
        repeat (3) @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule